// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one accepted read or write burst request into the list of column addresses the data beats use, one address per clock. The caller presents a two-bit burst-length mode, a per-command length select bit, the starting column and the burst ordering (sequential or interleaved). It then pulses `start_i` while the sequencer is idle. The sequencer holds the request in registers and steps through a fixed eight-cycle bus slot.

The burst length is either fixed by the mode or taken from the per-command select bit. Every beat stays inside an aligned block of four or eight columns, wrapping at the block edge. Only the low two or three column bits change. A chopped burst still takes the whole eight-cycle slot, but only its first four beats are marked valid. The last valid beat is flagged. Flags show chop or full length, and a separate flag marks the reserved mode value.

Top module: `burst_col_seq`

## Requirements
- R1: Mode 2'b00 gives a full burst: `bl8_o` high, `chop_o` low and eight valid beats.
- R2: Mode 2'b10 gives a chopped burst: `chop_o` high, `bl8_o` low and four valid beats.
- R3: Mode 2'b01 reads the per-command select: `otf_sel_i`=0 gives a chopped burst and `otf_sel_i`=1 gives a full burst.
- R4: Mode 2'b11 runs as a full burst with `mode_err_o` high through the slot. All other modes keep `mode_err_o` low.
- R5: With `interleave_i`=0, beat n of a full burst has low bits [2:0] = (start[2:0]+n) mod 8. For a chop, beat n has bits [1:0] = (start[1:0]+n) mod 4. All higher column bits equal the start column.
- R6: With `interleave_i`=1, the low field is start XOR n instead, using the same field widths as R5.
- R7: A burst occupies exactly eight cycles of `busy_o`. `beat_valid_o` is high on beats 0 to 3 of a chop and on all eight beats of a full burst. `col_o` is zero whenever `beat_valid_o` is low.
- R8: `last_o` is high only on the final valid beat: beat 3 of a chop, beat 7 of a full burst.
- R9: A request is taken only when `busy_o` is low. Beat 0 appears in the cycle after acceptance. A `start_i` pulse during a burst changes nothing.
- R10: After reset, `busy_o`, `beat_valid_o`, `last_o`, `chop_o`, `bl8_o`, `mode_err_o` and `col_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request, taken when idle |
| bl_mode_i | input | 2 | Burst-length mode field |
| otf_sel_i | input | 1 | Per-command length select (1 = full) |
| interleave_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col_i | input | COL_W | Starting column |
| busy_o | output | 1 | Eight-cycle burst slot in progress |
| beat_valid_o | output | 1 | Current beat carries a valid column |
| col_o | output | COL_W | Column of the current beat |
| last_o | output | 1 | Final valid beat |
| chop_o | output | 1 | Active burst is a four-beat chop |
| bl8_o | output | 1 | Active burst is a full eight-beat burst |
| mode_err_o | output | 1 | Active burst used the reserved mode |

## Verification
A corrupted beat counter or latched request shows up on `col_o` within the same beat. Typical symptoms are a wrong low field, a changed block bit, or a column left nonzero after the valid beats end. A stuck or miscounted slot shows up when `busy_o` falls at the wrong cycle, or when `last_o` lands on a beat other than 3 or 7. The next accepted burst then starts late or early. A wrong decode of the length is visible from beat 0 on the chop and full flags, and at beat 4 on `beat_valid_o`.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  localparam int unsigned SLOT_BEATS = 8;
  localparam int unsigned BEAT_W     = $clog2(SLOT_BEATS);
  localparam int unsigned CHOP_BEATS = SLOT_BEATS / 2;

  typedef enum logic [1:0] {
    BL_FIX8 = 2'b00,
    BL_OTF  = 2'b01,
    BL_FIX4 = 2'b10,
    BL_RSVD = 2'b11
  } bl_mode_e;

  typedef struct packed {
    logic chop;
    logic err;
  } bl_sel_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       otf_sel_i,
  output bl_sel_t    sel_o
);
  bl_mode_e mode;
  assign mode = bl_mode_e'(mode_i);

  always_comb begin
    sel_o = '0;
    unique case (mode)
      BL_FIX8: sel_o.chop = 1'b0;
      BL_OTF:  sel_o.chop = ~otf_sel_i;
      BL_FIX4: sel_o.chop = 1'b1;
      BL_RSVD: sel_o.err  = 1'b1;  // reserved: run full length, flag it
      default: sel_o = '0;
    endcase
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int unsigned BEATS = 8,
  localparam int unsigned CW   = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  output logic          active_o,
  output logic [CW-1:0] beat_o
);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      beat_o   <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
    end else if (active_o) begin
      if (beat_o == LAST) begin
        active_o <= 1'b0;
        beat_o   <= '0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              chop_i,
  input  logic              interleave_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);
  localparam int unsigned W8 = BEAT_W;
  localparam int unsigned W4 = BEAT_W - 1;

  logic [W8-1:0] off8;
  logic [W4-1:0] off4;

  always_comb begin
    off8 = interleave_i ? (start_col_i[W8-1:0] ^ beat_i)
                        : (start_col_i[W8-1:0] + beat_i);
    off4 = interleave_i ? (start_col_i[W4-1:0] ^ beat_i[W4-1:0])
                        : (start_col_i[W4-1:0] + beat_i[W4-1:0]);
    col_o = start_col_i;
    if (chop_i) col_o[W4-1:0] = off4;
    else        col_o[W8-1:0] = off8;
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       bl_mode_i,
  input  logic             otf_sel_i,
  input  logic             interleave_i,
  input  logic [COL_W-1:0] col_i,
  output logic             busy_o,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             chop_o,
  output logic             bl8_o,
  output logic             mode_err_o
);
  localparam logic [BEAT_W-1:0] LAST_FULL = BEAT_W'(SLOT_BEATS - 1);
  localparam logic [BEAT_W-1:0] LAST_CHOP = BEAT_W'(CHOP_BEATS - 1);

  bl_sel_t           sel_d, sel_q;
  logic [COL_W-1:0]  start_col_q, gen_col;
  logic              il_q, active, accept;
  logic [BEAT_W-1:0] beat;

  assign accept = start_i & ~active;

  burst_len_decode u_dec (
    .mode_i   (bl_mode_i),
    .otf_sel_i(otf_sel_i),
    .sel_o    (sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      start_col_q <= '0;
      il_q        <= 1'b0;
    end else if (accept) begin
      sel_q       <= sel_d;
      start_col_q <= col_i;
      il_q        <= interleave_i;
    end
  end

  beat_counter #(.BEATS(SLOT_BEATS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .active_o(active),
    .beat_o  (beat)
  );

  col_addr_gen #(.COL_W(COL_W)) u_gen (
    .start_col_i (start_col_q),
    .chop_i      (sel_q.chop),
    .interleave_i(il_q),
    .beat_i      (beat),
    .col_o       (gen_col)
  );

  // chop: only the first half of the slot carries data
  assign beat_valid_o = active & (~sel_q.chop | (beat < BEAT_W'(CHOP_BEATS)));
  assign last_o       = active & (sel_q.chop ? (beat == LAST_CHOP) : (beat == LAST_FULL));
  assign col_o        = beat_valid_o ? gen_col : '0;
  assign busy_o       = active;
  assign chop_o       = active & sel_q.chop;
  assign bl8_o        = active & ~sel_q.chop;
  assign mode_err_o   = active & sel_q.err;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       bl_mode_i,
  input logic             otf_sel_i,
  input logic             interleave_i,
  input logic [COL_W-1:0] col_i,
  input logic             busy_o,
  input logic             beat_valid_o,
  input logic [COL_W-1:0] col_o,
  input logic             last_o,
  input logic             chop_o,
  input logic             bl8_o,
  input logic             mode_err_o
);
  assert_len_flags_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $onehot({chop_o, bl8_o}));

  assert_flags_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(chop_o | bl8_o | mode_err_o | beat_valid_o | last_o));

  assert_err_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> bl8_o);

  assert_block_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && $past(beat_valid_o) && $past(busy_o) && !$rose(busy_o))
      |-> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  assert_col_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_o |-> (col_o == '0));

  assert_last_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);

  assert_last_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !beat_valid_o);

  assert_chop_tail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chop_o && last_o) |=> (busy_o && chop_o));

  assert_slot_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(chop_o) && $stable(mode_err_o)));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int unsigned COL_W = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       bl_mode_i = '0;
  logic             otf_sel_i = 1'b0;
  logic             interleave_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             busy_o, beat_valid_o, last_o, chop_o, bl8_o, mode_err_o;
  logic [COL_W-1:0] col_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  burst_col_seq #(.COL_W(COL_W)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_chop(input logic [1:0] m, input logic otf);
    return (m == 2'b10) || (m == 2'b01 && !otf);
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input bit chop, input bit il, input int n);
    logic [COL_W-1:0] c = s;
    logic [2:0] nb = 3'(n);
    if (chop) c[1:0] = il ? (s[1:0] ^ nb[1:0]) : (s[1:0] + nb[1:0]);
    else      c[2:0] = il ? (s[2:0] ^ nb)      : (s[2:0] + nb);
    return c;
  endfunction

  task automatic run_burst(input logic [1:0] m, input logic otf, input logic il,
                           input logic [COL_W-1:0] s, input bit inject);
    bit ch = exp_chop(m, otf);
    string rl = (m == 2'b00) ? "R1" : (m == 2'b10) ? "R2" : (m == 2'b01) ? "R3" : "R4";
    string ra = il ? "R6" : "R5";
    @(negedge clk_i);
    start_i = 1'b1; bl_mode_i = m; otf_sel_i = otf; interleave_i = il; col_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int b = 0; b < 8; b++) begin
      bit v = !ch || (b < 4);
      chk("R9", "busy", busy_o, 1);
      chk(rl, "chop", chop_o, ch);
      chk(rl, "bl8", bl8_o, !ch);
      chk("R4", "mode_err", mode_err_o, m == 2'b11);
      chk("R7", "valid", beat_valid_o, v);
      chk("R8", "last", last_o, ch ? (b == 3) : (b == 7));
      if (v) chk(ra, "col", col_o, exp_col(s, ch, il, b));
      else   chk("R7", "col_idle", col_o, 0);
      if (inject && b == 2) begin
        start_i = 1'b1; bl_mode_i = ~m; otf_sel_i = ~otf;
        interleave_i = ~il; col_i = ~s;
      end
      if (b == 3) start_i = 1'b0;
      @(negedge clk_i);
    end
    chk("R9", "busy_end", busy_o, 0);
    chk("R7", "valid_end", beat_valid_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R10", "busy", busy_o, 0);
    chk("R10", "valid", beat_valid_o, 0);
    chk("R10", "col", col_o, 0);
    chk("R10", "flags", {last_o, chop_o, bl8_o, mode_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", "busy_after", busy_o, 0);

    run_burst(2'b00, 1'b0, 1'b0, 10'h3FE, 1'b0);
    run_burst(2'b00, 1'b1, 1'b1, 10'h2A5, 1'b0);
    run_burst(2'b10, 1'b1, 1'b0, 10'h007, 1'b0);
    run_burst(2'b10, 1'b0, 1'b1, 10'h3FF, 1'b0);
    run_burst(2'b01, 1'b0, 1'b0, 10'h0F3, 1'b0);
    run_burst(2'b01, 1'b1, 1'b0, 10'h0F5, 1'b1);
    run_burst(2'b11, 1'b0, 1'b1, 10'h1C6, 1'b1);
    run_burst(2'b01, 1'b0, 1'b1, 10'h002, 1'b1);

    for (int i = 0; i < 300; i++) begin
      run_burst(2'($urandom), 1'($urandom), 1'($urandom),
                COL_W'($urandom), 1'($urandom));
      if ($urandom_range(3) == 0) begin
        @(negedge clk_i);
        chk("R9", "idle_gap", busy_o, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule